// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Flush and Probe

A small fully associative translation cache that holds leaf page-table entries for a processor's memory-management unit. Each slot carries a valid flag, a 16-bit address-space number (context), a virtual page tag, the leaf level the entry maps (4 KiB page, 256 KiB segment or 16 MiB region) and the 32-bit entry itself. A lookup compares the virtual address against every slot at once. It ignores the tag bits that fall inside the slot's mapping span, and it returns the hit flag and the stored entry in the same cycle.

A table walker loads new entries through a fill port. The slot it writes is the lowest-numbered empty slot or, when no slot is empty, the one a round-robin pointer names. Software reaches the cache through a command port. A write command invalidates entries, and bits 11:8 of the command address choose how wide that invalidation is. A read command with the whole-cache code is a probe: it returns the cached entry that translates the given virtual page, or zero.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no slot is valid: every lookup misses and a probe returns zero.
- R2: A lookup hits when a slot is valid, its context equals `cur_ctx`, and `lk_vaddr` equals its tag over bits 31:12 (level 0, page), 31:18 (level 1, segment) or 31:24 (level 2, region); `fill_level` 3 is taken as page. `lk_hit` and `lk_pte` respond in the same cycle. When several slots match, the lowest-numbered one supplies `lk_pte`.
- R3: A write with `cmd_addr[11:8]` = 0, 1 or 2 invalidates every valid slot of the current context whose tag equals `cmd_addr` over bits 31:12, 31:18 or 31:24 respectively. The comparison uses the coarser of that span and the slot's own span, so a narrow flush that falls inside a large mapping removes that mapping.
- R4: A write with type 3 invalidates every slot whose context equals `cur_ctx`, whatever its address, and leaves all other contexts intact.
- R5: A write with type 4 invalidates every slot, ignoring context and address.
- R6: A write with type 5 to 15 changes nothing.
- R7: A read command raises `probe_valid` for exactly the next cycle. With type 4, `probe_data` then holds the entry that an R2 lookup of `cmd_addr` in `cur_ctx` would have returned in the command cycle, or zero on a miss. With any other type it holds zero.
- R8: An invalidation is visible from the cycle after the write command. In the command cycle itself a lookup does not hit a slot that the command removes, while slots the command does not remove still hit.
- R9: A fill goes to the lowest-numbered slot that is empty at the start of that cycle. When every slot is full it goes to the round-robin slot, and the pointer then moves to the next slot, wrapping after the last. The PTE stored has its page number in bits 31:8 and type code 2 in bits 1:0.
- R10: A filled entry can be looked up from the next cycle on, and it survives a flush issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_ctx | input | 16 | Current context, used by lookup, fill, flush and probe |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pte | output | 32 | Entry of the hitting slot, zero on a miss |
| fill_valid | input | 1 | Write a new entry this cycle |
| fill_vaddr | input | 32 | Virtual address of the new entry |
| fill_level | input | 2 | 0 page, 1 segment, 2 region |
| fill_pte | input | 32 | Leaf entry to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 flush, 0 probe read |
| cmd_addr | input | 32 | Command address: bits 11:8 type, upper bits virtual address |
| probe_valid | output | 1 | Probe result valid, one cycle after the read |
| probe_data | output | 32 | Probe result entry or zero |

## Verification
A lookup and a flush can fall in the same cycle. Lookups are then answered against the slots that remain, and the flush must also not eat a fill that arrives with it. The directed part issues a segment flush while looking up an address inside a region mapping that the flush removes. It then issues a whole-cache flush together with a fill. Random cycles mix fills, all flush types, probes and lookups from a small address pool, so these collisions recur often. A bench model answers each cycle's lookup only from the entries that the cycle's command would leave in place.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam int VA_W  = 32;
    localparam int PTE_W = 32;
    localparam int VPN_W = 20;
    localparam int CTX_W = 16;

    typedef enum logic [1:0] {
        LVL_PAGE   = 2'd0,
        LVL_SEG    = 2'd1,
        LVL_REGION = 2'd2
    } level_e;

    localparam logic [3:0] OP_PAGE   = 4'd0;
    localparam logic [3:0] OP_SEG    = 4'd1;
    localparam logic [3:0] OP_REGION = 4'd2;
    localparam logic [3:0] OP_CTX    = 4'd3;
    localparam logic [3:0] OP_ALL    = 4'd4;

    typedef struct packed {
        logic             valid;
        logic [CTX_W-1:0] ctx;
        logic [VPN_W-1:0] vpn;
        level_e           lvl;
        logic [PTE_W-1:0] pte;
    } slot_t;

    function automatic level_e level_of(input logic [1:0] code);
        case (code)
            2'd1:    return LVL_SEG;
            2'd2:    return LVL_REGION;
            default: return LVL_PAGE;
        endcase
    endfunction

    // Tag bits that take part in a compare for a given mapping span
    function automatic logic [VPN_W-1:0] span_mask(input level_e l);
        case (l)
            LVL_SEG:    return 20'hFFFC0;
            LVL_REGION: return 20'hFF000;
            default:    return 20'hFFFFF;
        endcase
    endfunction

endpackage

// File: rtl/ctx_tlb_slot_match.sv
module ctx_tlb_slot_match
    import ctx_tlb_pkg::*;
(
    input  slot_t            slot,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [VPN_W-1:0] cmd_vpn,
    input  logic [3:0]       cmd_op,
    input  logic             cmd_flush,
    output logic             lk_match,
    output logic             probe_match,
    output logic             kill
);
    logic [VPN_W-1:0] own_mask;
    logic [VPN_W-1:0] fl_mask;
    logic             ctx_eq;
    logic             scope_hit;

    always_comb begin
        own_mask    = span_mask(slot.lvl);
        ctx_eq      = (slot.ctx == cur_ctx);
        lk_match    = slot.valid && ctx_eq && ((lk_vpn & own_mask) == (slot.vpn & own_mask));
        probe_match = slot.valid && ctx_eq && ((cmd_vpn & own_mask) == (slot.vpn & own_mask));
        fl_mask     = own_mask;
        scope_hit   = 1'b0;
        case (cmd_op)
            OP_PAGE, OP_SEG, OP_REGION: begin
                fl_mask   = own_mask & span_mask(level_of(cmd_op[1:0]));
                scope_hit = ctx_eq && ((cmd_vpn & fl_mask) == (slot.vpn & fl_mask));
            end
            OP_CTX:  scope_hit = ctx_eq;
            OP_ALL:  scope_hit = 1'b1;
            default: scope_hit = 1'b0;
        endcase
        kill = cmd_flush && slot.valid && scope_hit;
    end
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N_SLOTS = 8,
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] valid_vec,
    input  logic               fill,
    output logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill && !any_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    a_r9_rr_in_range: assert property (@(posedge clk) disable iff (rst)
        rr_q <= LAST);
    a_r9_free_first: assert property (@(posedge clk) disable iff (rst)
        (fill && !(&valid_vec)) |-> !valid_vec[victim]);
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cur_ctx,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic [31:0] lk_pte,
    input  logic        fill_valid,
    input  logic [31:0] fill_vaddr,
    input  logic [1:0]  fill_level,
    input  logic [31:0] fill_pte,
    input  logic        cmd_valid,
    input  logic        cmd_write,
    input  logic [31:0] cmd_addr,
    output logic        probe_valid,
    output logic [31:0] probe_data
);
    slot_t              slot_view [N_SLOTS];
    logic [N_SLOTS-1:0] valid_vec;
    logic [N_SLOTS-1:0] lk_match_vec;
    logic [N_SLOTS-1:0] pr_match_vec;
    logic [N_SLOTS-1:0] kill_vec;
    logic [N_SLOTS-1:0] lk_sel;
    logic [N_SLOTS-1:0] fill_oh;
    logic [IDX_W-1:0]   victim_idx;
    logic               cmd_flush;
    logic               cmd_read;
    logic [PTE_W-1:0]   probe_pick;
    logic               probe_any;
    level_e             fill_lvl;

    assign cmd_flush = cmd_valid && cmd_write;
    assign cmd_read  = cmd_valid && !cmd_write;
    assign fill_lvl  = level_of(fill_level);

    ctx_tlb_victim #(.N_SLOTS(N_SLOTS)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .fill      (fill_valid),
        .victim    (victim_idx)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        slot_t s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '0;
            end else if (fill_valid && victim_idx == IDX_W'(g)) begin
                s_q.valid <= 1'b1;
                s_q.ctx   <= cur_ctx;
                s_q.vpn   <= fill_vaddr[31:12] & span_mask(fill_lvl);
                s_q.lvl   <= fill_lvl;
                s_q.pte   <= fill_pte;
            end else if (kill_vec[g]) begin
                s_q.valid <= 1'b0;
            end
        end

        assign slot_view[g] = s_q;
        assign valid_vec[g] = s_q.valid;
        assign fill_oh[g]   = fill_valid && (victim_idx == IDX_W'(g));

        ctx_tlb_slot_match u_match (
            .slot        (s_q),
            .cur_ctx     (cur_ctx),
            .lk_vpn      (lk_vaddr[31:12]),
            .cmd_vpn     (cmd_addr[31:12]),
            .cmd_op      (cmd_addr[11:8]),
            .cmd_flush   (cmd_flush),
            .lk_match    (lk_match_vec[g]),
            .probe_match (pr_match_vec[g]),
            .kill        (kill_vec[g])
        );
    end

    // Lowest-numbered surviving match wins the lookup
    always_comb begin
        lk_sel = '0;
        lk_hit = 1'b0;
        lk_pte = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!lk_hit && lk_match_vec[i] && !kill_vec[i]) begin
                lk_sel[i] = 1'b1;
                lk_hit    = 1'b1;
                lk_pte    = slot_view[i].pte;
            end
        end
    end

    always_comb begin
        probe_any  = 1'b0;
        probe_pick = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (!probe_any && pr_match_vec[i]) begin
                probe_any  = 1'b1;
                probe_pick = slot_view[i].pte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            probe_valid <= 1'b0;
            probe_data  <= '0;
        end else begin
            probe_valid <= cmd_read;
            probe_data  <= (cmd_read && cmd_addr[11:8] == OP_ALL) ? probe_pick : '0;
        end
    end

    // R1: state is empty on the first cycle out of reset
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));
    // R2: at most one slot drives the lookup result
    a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_sel));
    // R5: whole-cache flush without a fill leaves nothing valid
    a_r5_all_cleared: assert property (@(posedge clk) disable iff (rst)
        (cmd_flush && cmd_addr[11:8] == OP_ALL && !fill_valid) |=> (valid_vec == '0));
    // R7: probe result pulses one cycle after each read
    a_r7_probe_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_read |=> probe_valid);
    a_r7_probe_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_read |=> !probe_valid);
    // R8: removed slots are invalid in the following cycle
    a_r8_kill_lands: assert property (@(posedge clk) disable iff (rst)
        (|kill_vec) |=> ((valid_vec & $past(kill_vec) & ~$past(fill_oh)) == '0));
    // R10: a filled slot is valid next cycle, even under a flush
    a_r10_fill_lands: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> valid_vec[$past(victim_idx)]);
endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cur_ctx;
    logic [31:0] lk_vaddr;
    logic        lk_hit;
    logic [31:0] lk_pte;
    logic        fill_valid;
    logic [31:0] fill_vaddr;
    logic [1:0]  fill_level;
    logic [31:0] fill_pte;
    logic        cmd_valid;
    logic        cmd_write;
    logic [31:0] cmd_addr;
    logic        probe_valid;
    logic [31:0] probe_data;

    always #5 clk = ~clk;

    ctx_tlb #(.N_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .cur_ctx(cur_ctx),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_pte(lk_pte),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
        .fill_level(fill_level), .fill_pte(fill_pte),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .probe_valid(probe_valid), .probe_data(probe_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    bit          m_v   [N];
    logic [15:0] m_ctx [N];
    logic [19:0] m_vpn [N];
    int          m_lvl [N];
    logic [31:0] m_pte [N];
    int          m_rr;

    function automatic logic [19:0] bmask(int l);
        if (l == 1) return 20'hFFFC0;
        if (l == 2) return 20'hFF000;
        return 20'hFFFFF;
    endfunction

    function automatic bit bmatch(int i, logic [31:0] va, logic [15:0] ctx);
        logic [19:0] mk;
        mk = bmask(m_lvl[i]);
        return m_v[i] && m_ctx[i] == ctx && ((va[31:12] & mk) == (m_vpn[i] & mk));
    endfunction

    function automatic bit bkill(int i, bit cv, bit cw, logic [31:0] ca, logic [15:0] ctx);
        int t;
        logic [19:0] fm;
        if (!(cv && cw && m_v[i])) return 0;
        t = int'(ca[11:8]);
        if (t <= 2) begin
            fm = bmask(t) & bmask(m_lvl[i]);
            return m_ctx[i] == ctx && ((ca[31:12] & fm) == (m_vpn[i] & fm));
        end
        if (t == 3) return m_ctx[i] == ctx;
        if (t == 4) return 1;
        return 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(string tag, bit fv, logic [31:0] fva, int flvl, logic [31:0] fpte,
                         bit cv, bit cw, logic [31:0] ca, logic [15:0] ctx, logic [31:0] lva);
        bit          e_hit;
        logic [31:0] e_pte;
        logic [31:0] e_probe;
        bit          kill [N];
        int          vic;
        bit          full;
        @(negedge clk);
        fill_valid = fv; fill_vaddr = fva; fill_level = 2'(flvl); fill_pte = fpte;
        cmd_valid = cv; cmd_write = cw; cmd_addr = ca; cur_ctx = ctx; lk_vaddr = lva;
        #1;
        e_hit = 0; e_pte = '0; e_probe = '0;
        for (int i = 0; i < N; i++) kill[i] = bkill(i, cv, cw, ca, ctx);
        for (int i = 0; i < N; i++)
            if (!e_hit && bmatch(i, lva, ctx) && !kill[i]) begin e_hit = 1; e_pte = m_pte[i]; end
        check({tag, " lookup hit"}, 32'(lk_hit), 32'(e_hit));
        check({tag, " lookup pte"}, lk_pte, e_pte);
        if (cv && !cw && ca[11:8] == 4'd4) begin
            for (int i = N - 1; i >= 0; i--) if (bmatch(i, ca, ctx)) e_probe = m_pte[i];
        end
        vic = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        full = (vic < 0);
        if (full) vic = m_rr;
        @(posedge clk);
        for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
        if (fv) begin
            m_v[vic] = 1; m_ctx[vic] = ctx; m_lvl[vic] = (flvl == 3) ? 0 : flvl;
            m_vpn[vic] = fva[31:12] & bmask(m_lvl[vic]); m_pte[vic] = fpte;
            if (full) m_rr = (m_rr + 1) % N;
        end
        #1;
        check({tag, " R7 probe_valid"}, 32'(probe_valid), 32'(cv && !cw));
        if (cv && !cw) check({tag, " R7 probe_data"}, probe_data, e_probe);
    endtask

    function automatic logic [31:0] mkpte(logic [23:0] ppn);
        return {ppn, 6'b0, 2'b10};
    endfunction

    task automatic idle(string tag, logic [15:0] ctx, logic [31:0] lva);
        cycle(tag, 0, 0, 0, 0, 0, 0, 0, ctx, lva);
    endtask

    task automatic fill(string tag, logic [31:0] va, int lvl, logic [31:0] pte, logic [15:0] ctx);
        cycle(tag, 1, va, lvl, pte, 0, 0, 0, ctx, va);
    endtask

    task automatic cmd(string tag, bit wr, logic [31:0] ca, logic [15:0] ctx, logic [31:0] lva);
        cycle(tag, 0, 0, 0, 0, 1, wr, ca, ctx, lva);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] va;
        int          r;
        void'($urandom(32'd7781));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_ctx[i] = 0; m_vpn[i] = 0; m_lvl[i] = 0; m_pte[i] = 0; end
        m_rr = 0;
        rst = 1; fill_valid = 0; fill_vaddr = 0; fill_level = 0; fill_pte = 0;
        cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cur_ctx = 16'd1; lk_vaddr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: empty after reset
        idle("R1 reset", 16'd1, 32'h1234_5000);
        check("R1 reset lk_hit", 32'(lk_hit), 32'd0);
        cmd("R1 reset probe", 0, 32'h1234_5400, 16'd1, 32'h0);
        check("R1 reset probe zero", probe_data, 32'd0);

        // R2: region mapping covers other pages in its span; page does not
        fill("R2 fill region", 32'h1234_5000, 2, mkpte(24'hABCDEF), 16'd1);
        fill("R2 fill page", 32'h2000_1000, 0, mkpte(24'h000111), 16'd1);
        idle("R2 region span", 16'd1, 32'h12FF_F000);
        check("R2 region span hit", 32'(lk_hit), 32'd1);
        idle("R2 page neighbour", 16'd1, 32'h2000_2000);
        check("R2 page neighbour miss", 32'(lk_hit), 32'd0);
        idle("R2 other ctx", 16'd2, 32'h1234_5000);
        check("R2 other ctx miss", 32'(lk_hit), 32'd0);
        cmd("R7 probe hit", 0, 32'h1230_0400, 16'd1, 32'h0);
        check("R7 probe region pte", probe_data, mkpte(24'hABCDEF));

        // R8/R3: segment flush inside region mapping, lookup same cycle
        cmd("R8 same-cycle flush", 1, 32'h1230_0100, 16'd1, 32'h1234_5000);
        check("R8 killed slot no hit", 32'(lk_hit), 32'd0);
        idle("R3 after seg flush", 16'd1, 32'h1234_5000);
        check("R3 region removed", 32'(lk_hit), 32'd0);
        cmd("R8 survivor", 1, 32'h1230_0100, 16'd1, 32'h2000_1000);
        check("R8 other slot still hits", 32'(lk_hit), 32'd1);

        // R6: reserved write types do nothing
        cmd("R6 type5", 1, 32'h2000_1500, 16'd1, 32'h0);
        cmd("R6 type15", 1, 32'h2000_1F00, 16'd1, 32'h0);
        idle("R6 still there", 16'd1, 32'h2000_1000);
        check("R6 entry kept", 32'(lk_hit), 32'd1);

        // R4: context flush
        fill("R4 fill ctx2", 32'h3000_0000, 1, mkpte(24'h000222), 16'd2);
        cmd("R4 ctx flush", 1, 32'h0000_0300, 16'd1, 32'h0);
        idle("R4 ctx1 gone", 16'd1, 32'h2000_1000);
        check("R4 ctx1 removed", 32'(lk_hit), 32'd0);
        idle("R4 ctx2 kept", 16'd2, 32'h3003_F000);
        check("R4 ctx2 kept", 32'(lk_hit), 32'd1);

        // R5 with R10: whole flush plus concurrent fill
        cycle("R10 fill under flush", 1, 32'h4000_0000, 0, mkpte(24'h000444), 1, 1, 32'h0000_0400, 16'd2, 32'h0);
        idle("R5 ctx2 gone", 16'd2, 32'h3000_0000);
        check("R5 all removed", 32'(lk_hit), 32'd0);
        idle("R10 new kept", 16'd2, 32'h4000_0000);
        check("R10 fill survives", 32'(lk_hit), 32'd1);
        cmd("R5 clear", 1, 32'h0000_0400, 16'd1, 32'h0);

        // R9: fill beyond capacity, round robin replacement
        for (int k = 0; k < N + 3; k++)
            fill("R9 fill", 32'h5000_0000 + (k << 12), 0, mkpte(24'(k + 16)), 16'd1);
        for (int k = 0; k < N + 3; k++)
            idle("R9 lookup", 16'd1, 32'h5000_0000 + (k << 12));
        idle("R9 oldest evicted", 16'd1, 32'h5000_0000);
        check("R9 slot0 replaced", 32'(lk_hit), 32'd0);

        // Random mix: R2 R3 R4 R5 R7 R9 R10
        for (int n = 0; n < 4000; n++) begin
            va = {7'b0001000, 1'($urandom_range(1)), 4'd0, 2'($urandom_range(3)),
                  4'd0, 2'($urandom_range(3)), 12'($urandom)};
            r = $urandom_range(99);
            cycle("R2 R3 R7 random",
                  r < 25, va, $urandom_range(3), mkpte(24'($urandom)),
                  r >= 15 && r < 45, r < 35,
                  {va[31:12], ($urandom_range(9) < 8) ? 4'($urandom_range(4)) : 4'($urandom_range(15)), 8'h0},
                  16'($urandom_range(1, 3)),
                  {7'b0001000, 1'($urandom_range(1)), 4'd0, 2'($urandom_range(3)),
                   4'd0, 2'($urandom_range(3)), 12'h0});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule